// File: doc/BRIEF.md
# DES / Triple-DES Stage Sequencer

This block is the control sequencer for a single-key or triple-key DES engine built around an iterated round datapath. A start pulse arrives when the most significant word of an input block has been written. The sequencer then spends one set-up cycle per key stage, during which the datapath loads its operand. After that it runs the sixteen rounds of the stage, one or two per clock depending on a parameter. For each stage it tells the datapath which key to use and whether that stage encrypts or decrypts. It drives a round-enable strobe and a round index that the key schedule can use. A status field shows which stage is running.

The mode inputs are sampled when a start is accepted and held for the whole operation. Triple-key encryption runs three stages: encrypt with key A, decrypt with key B, then encrypt with key C. Triple-key decryption runs the inverse: decrypt with key C, encrypt with key B, then decrypt with key A.

When the last stage finishes, a sticky done flag is set. Software clears the flag by writing a 1 to it. The flag drives an active-low interrupt that is gated by an interrupt enable. The block has no data streams. All of its pins are plain control and status levels or single-cycle strobes, so no back-pressure rules apply.

Top module: `des_stage_seq`

## Requirements
- R1: After reset, block_num_o is 0, stage_load_o and round_en_o are 0, done_o is 0 and irq_n_o is 1.
- R2: A start_i pulse is accepted only while the sequencer is idle. A start_i that arrives during an operation is ignored, and the operation continues with unchanged timing.
- R3: Each stage takes one set-up cycle (stage_load_o=1) followed by 16/ROUNDS_PER_CLK cycles with round_en_o=1. ROUNDS_PER_CLK may be 1 or 2. During the round cycles, round_num_o gives the index of the first round in that clock: it counts 0, 1, 2, … when ROUNDS_PER_CLK=1 and 0, 2, 4, … when ROUNDS_PER_CLK=2.
- R4: In single mode (triple_i=0) the operation is one stage using key A (key_sel_o=0), with stage_decrypt_o = !encrypt_i. The whole operation lasts 1+16/ROUNDS_PER_CLK cycles.
- R5: In triple mode the operation is three stages lasting 3·(1+16/ROUNDS_PER_CLK) cycles. The keys are encoded as key_sel_o = 0 for A, 1 for B and 2 for C. For encryption the stages are (key 0, encrypt), (key 1, decrypt), (key 2, encrypt). For decryption they are (key 2, decrypt), (key 1, encrypt), (key 0, decrypt).
- R6: block_num_o is 0 while idle. It is 1 throughout a single-mode operation, and it is 1, 2 and 3 during the three triple-mode stages.
- R7: done_o rises in the cycle after the last round of the final stage, never earlier, and it stays high until cleared.
- R8: A status write (stat_wr_i=1) with stat_wdone_i=1 clears done_o on the next cycle. A status write with stat_wdone_i=0 leaves done_o unchanged.
- R9: irq_n_o is 0 exactly when done_o=1 and irq_en_i=1. It therefore asserts in the same cycle that done_o rises.
- R10: While enable_i=0, start_i is ignored. Dropping enable_i during an operation returns the sequencer to idle on the next cycle without setting done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable |
| triple_i | input | 1 | 1 selects three-stage operation; sampled at start |
| encrypt_i | input | 1 | 1 encrypts, 0 decrypts; sampled at start |
| irq_en_i | input | 1 | Interrupt enable |
| start_i | input | 1 | Start strobe (top data word written) |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdone_i | input | 1 | Done bit of the status write data |
| key_sel_o | output | 2 | Key for the current stage: 0=A, 1=B, 2=C |
| stage_load_o | output | 1 | Set-up cycle of a stage |
| round_en_o | output | 1 | Round datapath advances this cycle |
| round_num_o | output | 4 | Index of the first round in this clock |
| stage_decrypt_o | output | 1 | Current stage runs the decrypt direction |
| block_num_o | output | 2 | Stage status: 0 idle, 1..3 stage number |
| done_o | output | 1 | Sticky completion flag |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The hardest situations to reach are a start strobe or a loss of enable that lands in the middle of an operation. In particular, the sequencer must be shown to stay on its original timing when a stray start arrives inside a stage boundary of the triple sequence. The random stimulus injects a start at a random cycle inside every operation. A single-cycle and a two-round-per-clock instance run side by side on the same inputs, so each injection hits the two instances at different points in their sequences. Directed cases separately drop enable part-way through a stage and check that done never rises.

// File: rtl/des_seq_pkg.sv
package des_seq_pkg;
  localparam int unsigned ROUNDS_PER_STAGE = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    KEY_A = 2'd0,
    KEY_B = 2'd1,
    KEY_C = 2'd2
  } key_sel_t;
endpackage

// File: rtl/des_round_ctr.sv
module des_round_ctr #(
  parameter int unsigned ROUNDS_PER_CLK = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  output logic [3:0] round_num,
  output logic       last
);
  localparam int unsigned CYC = des_seq_pkg::ROUNDS_PER_STAGE / ROUNDS_PER_CLK;
  localparam int unsigned CW  = $clog2(CYC);
  localparam logic [CW-1:0] LAST_CNT = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (step)    cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_CNT);

  generate
    if (ROUNDS_PER_CLK == 1) begin : g_one
      assign round_num = 4'(cnt_q);
    end else begin : g_two
      assign round_num = {cnt_q, 1'b0};
    end
  endgenerate
endmodule

// File: rtl/des_stage_map.sv
module des_stage_map (
  input  logic       triple,
  input  logic       encrypt,
  input  logic [1:0] stage,
  output logic [1:0] key_sel,
  output logic       decrypt
);
  import des_seq_pkg::*;

  always_comb begin
    if (!triple) begin
      key_sel = KEY_A;
      decrypt = !encrypt;
    end else if (encrypt) begin
      key_sel = stage;
      decrypt = (stage == 2'd1);
    end else begin
      key_sel = 2'd2 - stage;
      decrypt = (stage != 2'd1);
    end
  end
endmodule

// File: rtl/des_done_flag.sv
module des_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic done,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   done <= 1'b0;
    else if (set) done <= 1'b1;
    else if (clr) done <= 1'b0;
  end

  assign irq_n = !(done && irq_en);
endmodule

// File: rtl/des_stage_seq.sv
module des_stage_seq #(
  parameter int unsigned ROUNDS_PER_CLK = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       triple_i,
  input  logic       encrypt_i,
  input  logic       irq_en_i,
  input  logic       start_i,
  input  logic       stat_wr_i,
  input  logic       stat_wdone_i,
  output logic [1:0] key_sel_o,
  output logic       stage_load_o,
  output logic       round_en_o,
  output logic [3:0] round_num_o,
  output logic       stage_decrypt_o,
  output logic [1:0] block_num_o,
  output logic       done_o,
  output logic       irq_n_o
);
  import des_seq_pkg::*;

  seq_state_t state_q;
  logic [1:0] stage_q;
  logic       triple_q, enc_q;
  logic       rnd_last;
  logic       final_stage;
  logic       finish;

  assign final_stage = triple_q ? (stage_q == 2'd2) : (stage_q == 2'd0);
  assign finish      = enable_i && (state_q == SEQ_RUN) && rnd_last && final_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      stage_q  <= 2'd0;
      triple_q <= 1'b0;
      enc_q    <= 1'b0;
    end else if (!enable_i) begin
      state_q <= SEQ_IDLE;
      stage_q <= 2'd0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q  <= SEQ_SETUP;
          stage_q  <= 2'd0;
          triple_q <= triple_i;
          enc_q    <= encrypt_i;
        end
        SEQ_SETUP: state_q <= SEQ_RUN;
        SEQ_RUN: if (rnd_last) begin
          if (final_stage) begin
            state_q <= SEQ_IDLE;
            stage_q <= 2'd0;
          end else begin
            state_q <= SEQ_SETUP;
            stage_q <= stage_q + 2'd1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  des_round_ctr #(.ROUNDS_PER_CLK(ROUNDS_PER_CLK)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state_q != SEQ_RUN || !enable_i),
    .step      (state_q == SEQ_RUN),
    .round_num (round_num_o),
    .last      (rnd_last)
  );

  des_stage_map u_map (
    .triple  (triple_q),
    .encrypt (enc_q),
    .stage   (stage_q),
    .key_sel (key_sel_o),
    .decrypt (stage_decrypt_o)
  );

  des_done_flag u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (finish),
    .clr    (stat_wr_i && stat_wdone_i),
    .irq_en (irq_en_i),
    .done   (done_o),
    .irq_n  (irq_n_o)
  );

  assign stage_load_o = (state_q == SEQ_SETUP);
  assign round_en_o   = (state_q == SEQ_RUN);
  assign block_num_o  = (state_q == SEQ_IDLE) ? 2'd0 : stage_q + 2'd1;
endmodule

// File: rtl/des_stage_seq_chk.sv
module des_stage_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable_i,
  input logic       irq_en_i,
  input logic       stat_wr_i,
  input logic       stat_wdone_i,
  input logic [1:0] key_sel_o,
  input logic       stage_load_o,
  input logic       round_en_o,
  input logic [1:0] block_num_o,
  input logic       done_o,
  input logic       irq_n_o
);
  // R3
  load_round_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stage_load_o && round_en_o));

  // R6
  idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_num_o == 2'd0) == !(stage_load_o || round_en_o));

  // R7
  done_after_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(round_en_o));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && stat_wdone_i && block_num_o == 2'd0) |=> !done_o);

  // R8
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(stat_wr_i && stat_wdone_i)) |=> done_o);

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && irq_en_i) |-> !irq_n_o);

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> irq_n_o);

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> block_num_o == 2'd0);

  // R5
  key_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_num_o != 2'd0) |-> key_sel_o != 2'd3);
endmodule

bind des_stage_seq des_stage_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .irq_en_i     (irq_en_i),
  .stat_wr_i    (stat_wr_i),
  .stat_wdone_i (stat_wdone_i),
  .key_sel_o    (key_sel_o),
  .stage_load_o (stage_load_o),
  .round_en_o   (round_en_o),
  .block_num_o  (block_num_o),
  .done_o       (done_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/des_stage_seq_test.sv
`timescale 1ns/1ps
module des_stage_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0, triple_i = 1'b0, encrypt_i = 1'b0, irq_en_i = 1'b0;
  logic start_i = 1'b0, stat_wr_i = 1'b0, stat_wdone_i = 1'b0;

  logic [1:0] key_a, key_b, blk_a, blk_b;
  logic load_a, load_b, ren_a, ren_b, dec_a, dec_b, done_a, done_b, irq_a, irq_b;
  logic [3:0] rn_a, rn_b;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  des_stage_seq #(.ROUNDS_PER_CLK(1)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .triple_i(triple_i),
    .encrypt_i(encrypt_i), .irq_en_i(irq_en_i), .start_i(start_i),
    .stat_wr_i(stat_wr_i), .stat_wdone_i(stat_wdone_i), .key_sel_o(key_a),
    .stage_load_o(load_a), .round_en_o(ren_a), .round_num_o(rn_a),
    .stage_decrypt_o(dec_a), .block_num_o(blk_a), .done_o(done_a), .irq_n_o(irq_a));

  des_stage_seq #(.ROUNDS_PER_CLK(2)) uut_fast (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .triple_i(triple_i),
    .encrypt_i(encrypt_i), .irq_en_i(irq_en_i), .start_i(start_i),
    .stat_wr_i(stat_wr_i), .stat_wdone_i(stat_wdone_i), .key_sel_o(key_b),
    .stage_load_o(load_b), .round_en_o(ren_b), .round_num_o(rn_b),
    .stage_decrypt_o(dec_b), .block_num_o(blk_b), .done_o(done_b), .irq_n_o(irq_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Packed view {blk[12:11], load[10], ren[9], rnum[8:5], key[4:3], dec[2], done[1], 0}
  function automatic int unsigned exp_vec(int r, int k, bit tr, bit en);
    int n = 16 / r;
    int l = 1 + n;
    int s = tr ? 3 : 1;
    int stg, pos, key;
    bit dec;
    if (k >= s * l) return 32'h2;
    stg = k / l;
    pos = k % l;
    if (!tr) begin key = 0; dec = !en; end
    else if (en) begin key = stg; dec = (stg == 1); end
    else begin key = 2 - stg; dec = (stg != 1); end
    return ((stg + 1) << 11) | ((pos == 0) << 10) | ((pos != 0) << 9) |
           (((pos == 0) ? 0 : (pos - 1) * r) << 5) | (key << 3) | (dec << 2);
  endfunction

  function automatic int unsigned act_vec(logic [1:0] b, logic ld, logic re, logic [3:0] rn,
                                          logic [1:0] k, logic d, logic dn);
    if (b == 2'd0) return (int'(b) << 11) | (int'(ld) << 10) | (int'(re) << 9) | (int'(dn) << 1);
    return (int'(b) << 11) | (int'(ld) << 10) | (int'(re) << 9) | (int'(rn) << 5) |
           (int'(k) << 3) | (int'(d) << 2) | (int'(dn) << 1);
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_done();
    stat_wr_i = 1'b1; stat_wdone_i = 1'b1;
    tick();
    stat_wr_i = 1'b0; stat_wdone_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7 R9: one full operation, stray start injected at cycle inj
  task automatic run_op(bit tr, bit en, bit ie, int inj);
    int tmax = tr ? 51 : 17;
    int unsigned e1, e2, a1, a2;
    triple_i = tr; encrypt_i = en; irq_en_i = ie; start_i = 1'b1;
    tick();
    for (int k = 0; k <= tmax; k++) begin
      e1 = exp_vec(1, k, tr, en); e2 = exp_vec(2, k, tr, en);
      a1 = act_vec(blk_a, load_a, ren_a, rn_a, key_a, dec_a, done_a);
      a2 = act_vec(blk_b, load_b, ren_b, rn_b, key_b, dec_b, done_b);
      check(a1 == e1, tr ? "R3/R5/R6/R7 single-rate" : "R3/R4/R6/R7 single-rate", a1, e1);
      check(a2 == e2, tr ? "R3/R5/R6/R7 double-rate" : "R3/R4/R6/R7 double-rate", a2, e2);
      start_i = (k == inj);
      tick();
    end
    start_i = 1'b0;
    check(irq_a == !ie && irq_b == !ie, "R9 irq while done", {irq_a, irq_b}, {!ie, !ie});
    stat_wr_i = 1'b1; stat_wdone_i = 1'b0;
    tick();
    stat_wr_i = 1'b0;
    check(done_a && done_b, "R8 write 0 keeps done", {done_a, done_b}, 2'b11);
    clear_done();
    check(!done_a && !done_b && irq_a && irq_b, "R8/R9 write 1 clears",
          {done_a, done_b, irq_a, irq_b}, 4'b0011);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(); tick();
    // R1
    check(blk_a == 0 && !load_a && !ren_a && !done_a && irq_a, "R1 reset state",
          {blk_a, load_a, ren_a, done_a, irq_a}, 5'b00001);
    rst_n = 1'b1;
    tick();
    // R10: start ignored while disabled
    start_i = 1'b1; tick(); start_i = 1'b0; tick();
    check(blk_a == 0 && blk_b == 0 && !done_a, "R10 start ignored when disabled",
          {blk_a, blk_b}, 0);
    enable_i = 1'b1;
    // Directed corners
    run_op(1'b0, 1'b1, 1'b1, 99);
    run_op(1'b0, 1'b0, 1'b0, 3);
    run_op(1'b1, 1'b1, 1'b1, 8);
    run_op(1'b1, 1'b0, 1'b1, 17);
    // R10: enable dropped mid-operation
    triple_i = 1'b1; start_i = 1'b1; tick(); start_i = 1'b0;
    repeat (20) tick();
    enable_i = 1'b0; tick();
    check(blk_a == 0 && blk_b == 0, "R10 drop enable returns idle", {blk_a, blk_b}, 0);
    enable_i = 1'b1;
    repeat (60) tick();
    check(!done_a && !done_b, "R10 aborted op sets no done", {done_a, done_b}, 0);
    // Random operations with stray starts (R2)
    for (int i = 0; i < 40; i++) begin
      bit tr = $urandom_range(0, 1);
      run_op(tr, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             $urandom_range(0, tr ? 25 : 7));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule